// File: doc/BRIEF.md
# DMA Block Address Generator

This block produces the source and destination bus addresses for every beat of one DMA block transfer. A descriptor is presented on the inputs together with a one-cycle start pulse. The descriptor holds the address each side reaches once the block has finished, the number of beats, the beat width, an increment enable for each side, a select bit and a stride exponent. At start the block works back from the end addresses to the first-beat addresses. It then presents one address pair per beat on a valid/ready handshake and moves both addresses forward after each accepted beat.

A single select bit decides which side uses the multi-beat stride of 2^step beats. The other side always advances by exactly one beat. A side with its increment disabled keeps its loaded address for the whole block, as a peripheral data register would need. After the last accepted beat a one-cycle done pulse follows. A reserved beat width raises a one-cycle error pulse and no transfer starts. Data movement, bus protocol, arbitration and descriptor fetch are handled elsewhere.

Top module: `dma_addr_gen`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `beat_valid_o`, `done_o` and `cfg_err_o` are low.
- R2: The first beat presented after a start shows, for each side whose increment bit is 1, the address end − count × bytes × stride, computed modulo 2^ADDR_W. A side whose increment bit is 0 shows the loaded address unchanged. The first beat appears in the cycle after the start pulse.
- R3: With `step_sel_i` = 1, the source address advances by bytes × 2^`step_size_i` after each accepted beat and the destination address advances by bytes.
- R4: With `step_sel_i` = 0, the destination address advances by bytes × 2^`step_size_i` after each accepted beat and the source address advances by bytes.
- R5: A side whose increment bit (`src_inc_i` or `dst_inc_i`) is 0 presents the same address on every beat of the block.
- R6: `beat_size_i` values 0, 1 and 2 select 1, 2 and 4 bytes per beat.
- R7: A start with `beat_size_i` = 3 gives a `cfg_err_o` pulse one cycle long in the next cycle. No beat is presented and no done pulse occurs.
- R8: A start with `count_i` = 0 gives a `done_o` pulse one cycle long in the next cycle, and no beat is presented.
- R9: While `beat_valid_o` is high and `beat_ready_i` is low, the valid signal and both addresses hold their values. Exactly `count_i` beats are accepted per block.
- R10: `done_o` is high for exactly the one cycle that follows acceptance of the final beat, and `beat_valid_o` is low in that cycle.
- R11: A start pulse that arrives while a block is in progress is ignored. The running block keeps its addresses and beat count, and no further block follows it.
- R12: Address arithmetic wraps modulo 2^ADDR_W, both when the start address is derived and when addresses advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle pulse that loads the descriptor |
| src_end_i | input | ADDR_W | Source end-of-block address (or the fixed address) |
| dst_end_i | input | ADDR_W | Destination end-of-block address (or the fixed address) |
| count_i | input | CNT_W | Number of beats in the block |
| beat_size_i | input | 2 | Beat width: 0=1 byte, 1=2 bytes, 2=4 bytes, 3 reserved |
| src_inc_i | input | 1 | Source increment enable |
| dst_inc_i | input | 1 | Destination increment enable |
| step_sel_i | input | 1 | 1: stride on source, 0: stride on destination |
| step_size_i | input | STEP_W | Stride exponent, in beats (2^value) |
| beat_valid_o | output | 1 | Address pair for the current beat is valid |
| beat_ready_i | input | 1 | Consumer accepts the current beat |
| src_addr_o | output | ADDR_W | Source address of the current beat |
| dst_addr_o | output | ADDR_W | Destination address of the current beat |
| done_o | output | 1 | One-cycle pulse after the final beat |
| cfg_err_o | output | 1 | One-cycle pulse on a start with the reserved beat size |

## Verification
The bench builds the block with its defaults: ADDR_W = 32, CNT_W = 16 and STEP_W = 3. A 32-bit address lets an end address close to zero force the derived start address to wrap below zero and then climb back across zero. A 3-bit step field allows strides of up to 128 beats, so a small beat count combined with a large exponent still produces large, distinct steps on each side. Together with both settings of the select bit, these values cover the back-calculation, the step applied to each side and the behaviour of a fixed address.

// File: rtl/dmaag_pkg.sv
package dmaag_pkg;

    typedef enum logic [1:0] {
        BSZ_1B   = 2'd0,
        BSZ_2B   = 2'd1,
        BSZ_4B   = 2'd2,
        BSZ_RSVD = 2'd3
    } beat_size_e;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    localparam int unsigned SIDES    = 2;
    localparam int unsigned SIDE_SRC = 0;
    localparam int unsigned SIDE_DST = 1;

    typedef struct packed {
        logic inc;
        logic strided;
    } lane_mode_t;

    function automatic logic [1:0] size_log2(beat_size_e sz);
        case (sz)
            BSZ_1B:  return 2'd0;
            BSZ_2B:  return 2'd1;
            BSZ_4B:  return 2'd2;
            default: return 2'd0;
        endcase
    endfunction

    function automatic logic size_legal(beat_size_e sz);
        return sz != BSZ_RSVD;
    endfunction

endpackage

// File: rtl/dmaag_stride.sv
module dmaag_stride
    import dmaag_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned STEP_W = 3
) (
    input  logic [ADDR_W-1:0] end_addr,
    input  logic [CNT_W-1:0]  count,
    input  lane_mode_t        mode,
    input  logic [1:0]        bytes_log2,
    input  logic [STEP_W-1:0] step_log2,
    output logic [ADDR_W-1:0] first_addr,
    output logic [ADDR_W-1:0] step_bytes
);
    localparam int unsigned SH_W = STEP_W + 3;

    logic [SH_W-1:0]   shamt;
    logic [ADDR_W-1:0] span;

    always_comb begin
        shamt = SH_W'(bytes_log2) + (mode.strided ? SH_W'(step_log2) : SH_W'(0));
        span  = ADDR_W'(count) << shamt;
        if (mode.inc) begin
            step_bytes = ADDR_W'(1) << shamt;
            first_addr = end_addr - span;
        end else begin
            step_bytes = '0;
            first_addr = end_addr;
        end
    end
endmodule

// File: rtl/dmaag_lane.sv
module dmaag_lane #(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              adv,
    input  logic [ADDR_W-1:0] first_addr,
    input  logic [ADDR_W-1:0] step_bytes,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] step_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            step_q <= '0;
        end else if (load) begin
            addr_q <= first_addr;
            step_q <= step_bytes;
        end else if (adv) begin
            addr_q <= addr_q + step_q;
        end
    end

    assign addr = addr_q;
endmodule

// File: rtl/dmaag_seq.sv
module dmaag_seq
    import dmaag_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] count,
    input  logic             cfg_ok,
    input  logic             ready,
    output logic             valid,
    output logic             load,
    output logic             adv,
    output logic             done,
    output logic             err
);
    phase_e           phase_q;
    logic [CNT_W-1:0] left_q;
    logic             done_q;
    logic             err_q;
    logic             accept;
    logic             last;

    always_comb begin
        valid  = (phase_q == PH_RUN);
        accept = valid && ready;
        last   = (left_q == CNT_W'(1));
        load   = (phase_q == PH_IDLE) && start && cfg_ok && (count != '0);
        adv    = accept && !last;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            left_q  <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        if (!cfg_ok) begin
                            err_q <= 1'b1;
                        end else if (count == '0) begin
                            done_q <= 1'b1;
                        end else begin
                            left_q  <= count;
                            phase_q <= PH_RUN;
                        end
                    end
                end
                PH_RUN: begin
                    if (accept) begin
                        if (last) begin
                            phase_q <= PH_IDLE;
                            done_q  <= 1'b1;
                        end
                        left_q <= left_q - CNT_W'(1);
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

    assign done = done_q;
    assign err  = err_q;
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
    import dmaag_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned STEP_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] src_end_i,
    input  logic [ADDR_W-1:0] dst_end_i,
    input  logic [CNT_W-1:0]  count_i,
    input  logic [1:0]        beat_size_i,
    input  logic              src_inc_i,
    input  logic              dst_inc_i,
    input  logic              step_sel_i,
    input  logic [STEP_W-1:0] step_size_i,
    output logic              beat_valid_o,
    input  logic              beat_ready_i,
    output logic [ADDR_W-1:0] src_addr_o,
    output logic [ADDR_W-1:0] dst_addr_o,
    output logic              done_o,
    output logic              cfg_err_o
);
    beat_size_e                   bsz;
    logic [1:0]                   bytes_log2;
    logic                         cfg_ok;
    logic                         load;
    logic                         adv;
    lane_mode_t [SIDES-1:0]       mode;
    logic [SIDES-1:0][ADDR_W-1:0] end_a;
    logic [SIDES-1:0][ADDR_W-1:0] first_a;
    logic [SIDES-1:0][ADDR_W-1:0] step_a;
    logic [SIDES-1:0][ADDR_W-1:0] addr_a;

    always_comb begin
        bsz        = beat_size_e'(beat_size_i);
        bytes_log2 = size_log2(bsz);
        cfg_ok     = size_legal(bsz);
        mode[SIDE_SRC] = '{inc: src_inc_i, strided: step_sel_i};
        mode[SIDE_DST] = '{inc: dst_inc_i, strided: !step_sel_i};
        end_a[SIDE_SRC] = src_end_i;
        end_a[SIDE_DST] = dst_end_i;
    end

    dmaag_seq #(.CNT_W(CNT_W)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (start_i),
        .count  (count_i),
        .cfg_ok (cfg_ok),
        .ready  (beat_ready_i),
        .valid  (beat_valid_o),
        .load   (load),
        .adv    (adv),
        .done   (done_o),
        .err    (cfg_err_o)
    );

    for (genvar s = 0; s < SIDES; s++) begin : g_side
        dmaag_stride #(
            .ADDR_W (ADDR_W),
            .CNT_W  (CNT_W),
            .STEP_W (STEP_W)
        ) u_stride (
            .end_addr   (end_a[s]),
            .count      (count_i),
            .mode       (mode[s]),
            .bytes_log2 (bytes_log2),
            .step_log2  (step_size_i),
            .first_addr (first_a[s]),
            .step_bytes (step_a[s])
        );

        dmaag_lane #(.ADDR_W(ADDR_W)) u_lane (
            .clk        (clk),
            .rst        (rst),
            .load       (load),
            .adv        (adv),
            .first_addr (first_a[s]),
            .step_bytes (step_a[s]),
            .addr       (addr_a[s])
        );
    end

    assign src_addr_o = addr_a[SIDE_SRC];
    assign dst_addr_o = addr_a[SIDE_DST];
endmodule

// File: rtl/dma_addr_gen_chk.sv
module dma_addr_gen_chk #(
    parameter int unsigned ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              beat_valid_o,
    input logic              beat_ready_i,
    input logic [ADDR_W-1:0] src_addr_o,
    input logic [ADDR_W-1:0] dst_addr_o,
    input logic              done_o,
    input logic              cfg_err_o
);
    // R1: outputs quiet in the cycle after reset is sampled
    assert_quiet_reset_R1: assert property (@(posedge clk)
        rst |=> (!beat_valid_o && !done_o && !cfg_err_o));

    // R9: a stalled beat keeps its addresses
    assert_stall_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (beat_valid_o && !beat_ready_i) |=>
            (beat_valid_o && $stable(src_addr_o) && $stable(dst_addr_o)));

    // R10: done is a single-cycle pulse
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R10: done never overlaps a presented beat
    assert_done_no_beat_R10: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !beat_valid_o);

    // R7: error pulse is single-cycle, no beat follows it
    assert_err_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        cfg_err_o |=> (!cfg_err_o && !beat_valid_o && !done_o));

    // R7: at most one of beat, done, error at a time
    assert_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({beat_valid_o, done_o, cfg_err_o}));
endmodule

bind dma_addr_gen dma_addr_gen_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .beat_valid_o (beat_valid_o),
    .beat_ready_i (beat_ready_i),
    .src_addr_o   (src_addr_o),
    .dst_addr_o   (dst_addr_o),
    .done_o       (done_o),
    .cfg_err_o    (cfg_err_o)
);

// File: tb/dma_addr_gen_test.sv
`timescale 1ns/1ps
module dma_addr_gen_test;
    localparam int unsigned AW = 32;
    localparam int unsigned CW = 16;
    localparam int unsigned SW = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start_i = 1'b0;
    logic [AW-1:0] src_end_i = '0;
    logic [AW-1:0] dst_end_i = '0;
    logic [CW-1:0] count_i = '0;
    logic [1:0]    beat_size_i = '0;
    logic          src_inc_i = 1'b0;
    logic          dst_inc_i = 1'b0;
    logic          step_sel_i = 1'b0;
    logic [SW-1:0] step_size_i = '0;
    logic          beat_ready_i = 1'b0;
    logic          beat_valid_o;
    logic [AW-1:0] src_addr_o;
    logic [AW-1:0] dst_addr_o;
    logic          done_o;
    logic          cfg_err_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    dma_addr_gen #(.ADDR_W(AW), .CNT_W(CW), .STEP_W(SW)) uut (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start_i),
        .src_end_i    (src_end_i),
        .dst_end_i    (dst_end_i),
        .count_i      (count_i),
        .beat_size_i  (beat_size_i),
        .src_inc_i    (src_inc_i),
        .dst_inc_i    (dst_inc_i),
        .step_sel_i   (step_sel_i),
        .step_size_i  (step_size_i),
        .beat_valid_o (beat_valid_o),
        .beat_ready_i (beat_ready_i),
        .src_addr_o   (src_addr_o),
        .dst_addr_o   (dst_addr_o),
        .done_o       (done_o),
        .cfg_err_o    (cfg_err_o)
    );

    task automatic check(input string req, input string what,
                         input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    // Runs one block; stall inserts a ready-low cycle on even beats,
    // poke pulses start during the first stall.
    task automatic run_block(input string req,
                             input logic [AW-1:0] s_end, input logic [AW-1:0] d_end,
                             input int cnt, input int sz,
                             input bit s_inc, input bit d_inc, input bit sel,
                             input int ss, input bit stall, input bit poke);
        logic [AW-1:0] bytes, s_step, d_step, s_exp, d_exp;
        bytes  = 32'd1 << sz;
        s_step = s_inc ? (bytes << (sel ? ss : 0)) : 32'd0;
        d_step = d_inc ? (bytes << (sel ? 0 : ss)) : 32'd0;
        s_exp  = s_end - s_step * 32'(cnt);
        d_exp  = d_end - d_step * 32'(cnt);
        src_end_i = s_end; dst_end_i = d_end; count_i = CW'(cnt);
        beat_size_i = 2'(sz); src_inc_i = s_inc; dst_inc_i = d_inc;
        step_sel_i = sel; step_size_i = SW'(ss);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        for (int i = 0; i < cnt; i++) begin
            check(req, $sformatf("beat %0d valid", i), 32'(beat_valid_o), 32'd1);
            check(req, $sformatf("beat %0d src", i), src_addr_o, s_exp);
            check(req, $sformatf("beat %0d dst", i), dst_addr_o, d_exp);
            if (stall && (i % 2 == 0)) begin
                beat_ready_i = 1'b0;
                if (poke && i == 0) begin
                    start_i = 1'b1; count_i = CW'(1);
                    src_end_i = 32'h0; dst_end_i = 32'h0;
                end
                @(negedge clk);
                start_i = 1'b0;
                check("R9", "stalled valid", 32'(beat_valid_o), 32'd1);
                check("R9", "stalled src", src_addr_o, s_exp);
                check("R9", "stalled dst", dst_addr_o, d_exp);
            end
            beat_ready_i = 1'b1;
            @(negedge clk);
            s_exp = s_exp + s_step;
            d_exp = d_exp + d_step;
        end
        beat_ready_i = 1'b0;
        check("R10", "done after last beat", 32'(done_o), 32'd1);
        check("R10", "valid low with done", 32'(beat_valid_o), 32'd0);
        @(negedge clk);
        check("R10", "done one cycle", 32'(done_o), 32'd0);
        check(poke ? "R11" : "R9", "no extra beat", 32'(beat_valid_o), 32'd0);
        @(negedge clk);
        check(poke ? "R11" : "R9", "still idle", 32'(beat_valid_o), 32'd0);
    endtask

    task automatic t_reset();
        check("R1", "valid in reset", 32'(beat_valid_o), 32'd0);
        check("R1", "done in reset", 32'(done_o), 32'd0);
        check("R1", "err in reset", 32'(cfg_err_o), 32'd0);
    endtask

    task automatic t_reserved_size();
        src_end_i = 32'h100; dst_end_i = 32'h200; count_i = CW'(4);
        beat_size_i = 2'd3; src_inc_i = 1'b1; dst_inc_i = 1'b1;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check("R7", "err pulse", 32'(cfg_err_o), 32'd1);
        check("R7", "no beat", 32'(beat_valid_o), 32'd0);
        check("R7", "no done", 32'(done_o), 32'd0);
        @(negedge clk);
        check("R7", "err cleared", 32'(cfg_err_o), 32'd0);
        check("R7", "still no beat", 32'(beat_valid_o), 32'd0);
    endtask

    task automatic t_zero_count();
        src_end_i = 32'h40; dst_end_i = 32'h80; count_i = '0;
        beat_size_i = 2'd2; src_inc_i = 1'b1; dst_inc_i = 1'b1;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check("R8", "immediate done", 32'(done_o), 32'd1);
        check("R8", "no beat", 32'(beat_valid_o), 32'd0);
        @(negedge clk);
        check("R8", "done cleared", 32'(done_o), 32'd0);
        check("R8", "still no beat", 32'(beat_valid_o), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        // R3 R2: source strided by two beats of 4 bytes, destination fixed
        run_block("R3", 32'h2000_0040, 32'h4000_0000, 4, 2, 1, 0, 1, 1, 0, 0);
        // R6 R5: byte beats, source one beat per step, with stalls
        run_block("R6", 32'h0000_1005, 32'h4000_0010, 5, 0, 1, 0, 0, 0, 1, 0);
        // R4 R6: halfword beats, destination strided by four beats
        run_block("R4", 32'h0000_3000, 32'h0000_5000, 3, 1, 1, 1, 0, 2, 0, 0);
        // R5: both sides fixed
        run_block("R5", 32'h1234_5678, 32'h8765_4320, 3, 2, 0, 0, 1, 3, 1, 0);
        // R3: both incrementing, source strided by eight beats
        run_block("R3", 32'h0000_0800, 32'h0000_0900, 2, 1, 1, 1, 1, 3, 0, 0);
        // R12: derived start wraps below zero and addresses climb across it
        run_block("R12", 32'h0000_0008, 32'h0000_0004, 4, 2, 1, 1, 0, 0, 0, 0);
        // R11: start during a block is ignored
        run_block("R11", 32'h0000_6000, 32'h0000_7000, 3, 2, 1, 1, 1, 0, 1, 1);
        t_reserved_size();
        t_zero_count();
        // R2: start immediately after a zero-count block
        run_block("R2", 32'hFFFF_FFF0, 32'h0000_0010, 2, 2, 1, 1, 0, 1, 0, 0);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule